// File: doc/BRIEF.md
# DMA Completion Status, Interrupt and Wait-Condition Unit

This block collects the end-of-transfer events of a ten-channel DMA engine into one status word. Each channel raises a one-cycle done pulse, and that pulse latches a flag for the channel. Software sees a single 32-bit word that holds both the flags and a set of per-channel interrupt enables. In one write to that word, software can acknowledge flags and flip enables.

The block drives two outputs. The first is a registered interrupt line, asserted whenever an enabled channel has a pending flag. The second is a wait-condition line for a processor instruction that stalls until a chosen set of channels have all finished. A second register word selects the channels that take part in that condition. The condition is evaluated again only when software writes one of the two words. A channel finishing on its own does not update the condition line.

Top module: `dma_irq_cond_unit`

## Requirements
- R1: After reset the status flags, enable bits and channel-select word are all zero, `irqPending` is 0 and `waitCond` is 1.
- R2: A one on `chanDone[i]` sets status flag i. The flags appear at `regRdData[9:0]` when `regSel` is 0, and `regRdData[15:10]` read as zero.
- R3: A write with `regSel` = 0 clears each status flag whose bit in `regWrData[15:0]` is 1. Flags whose bit is 0 keep their value.
- R4: The same write inverts each enable bit whose bit in `regWrData[31:16]` is 1. Enable bit j reads back at `regRdData[16+j]` when `regSel` is 0.
- R5: `irqPending` equals, one clock after the state changes, the OR over channels 0..9 of (enable bit AND status flag). Enable bits 15:10 are stored but never raise the line.
- R6: A write with `regSel` = 1 loads `regWrData[9:0]` into the channel-select word and leaves flags and enables untouched. With `regSel` = 1 the read returns the select word in bits 9:0 and zero in bits 31:10.
- R7: On the clock after any write (either word), `waitCond` becomes 1 exactly when every selected channel has its status flag set. With no channel selected it becomes 1.
- R8: Between writes, `waitCond` keeps its value even when completions change the status flags.
- R9: When a done pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| chanDone | input | 10 | One-cycle completion pulse per channel |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Word select: 0 = status/enable word, 1 = channel-select word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected word (combinational) |
| irqPending | output | 1 | Registered interrupt request |
| waitCond | output | 1 | Registered wait condition for the processor |

## Verification
The bench checks that the upper half of the word toggles and does not set. Writing the same enable pattern twice must return the enable to zero; a design that sets the bit would leave it on and keep the interrupt raised. The bench then lets a selected channel finish with no write and checks that `waitCond` stays put until a zero-data write to the status word. A design that evaluates the condition continuously would flip the line early. It also drives a done pulse together with a clearing write on the same flag, which a clear-priority design would lose. Finally, it writes only to enable bits above channel 9 and checks that the interrupt stays low.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  parameter int DefNumChan = 10;
  parameter int DefRegW    = 32;

  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic statWr;    // write to the status/enable word this cycle
    logic ctrlWr;    // write to the channel-select word this cycle
    logic condLoad;  // reload the wait condition from the current state
  } dmairq_strobe_t;

endpackage

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
  import dmairq_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           regWrEn,
  input  logic           regSel,
  output dmairq_strobe_t stb
);

  logic condLoadQ;

  // The condition is reloaded one cycle after a write, when the written
  // state is already visible in the registers.
  always_ff @(posedge clk) begin
    if (!rstN) condLoadQ <= 1'b0;
    else       condLoadQ <= regWrEn;
  end

  always_comb begin
    stb.statWr   = regWrEn && !regSel;
    stb.ctrlWr   = regWrEn &&  regSel;
    stb.condLoad = condLoadQ;
  end

  // R7: every write is followed by a condition reload
  p_reload_after_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> stb.condLoad);

  // R6: a single write never targets both words
  p_single_target_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.statWr, stb.ctrlWr}));

endmodule

// File: rtl/dmairq_datapath.sv
module dmairq_datapath
  import dmairq_pkg::*;
#(
  parameter int NumChan = DefNumChan,
  parameter int RegW    = DefRegW
) (
  input  logic                clk,
  input  logic                rstN,
  input  dmairq_strobe_t      stb,
  input  logic [NumChan-1:0]  chanDone,
  input  logic                regSel,
  input  logic [RegW-1:0]     regWrData,
  output logic [RegW-1:0]     regRdData,
  output logic                irqPending,
  output logic                waitCond
);

  localparam int HalfW = RegW / 2;

  logic [NumChan-1:0] statusQ;
  logic [HalfW-1:0]   maskQ;
  logic [NumChan-1:0] ctrlQ;
  logic               irqQ;
  logic               condQ;

  logic [NumChan-1:0] clrBits;
  logic [HalfW-1:0]   toggleBits;
  logic [NumChan-1:0] pendVec;
  logic               condNow;
  logic [HalfW-1:0]   statusWide;
  logic [RegW-1:0]    ctrlWide;

  assign clrBits    = regWrData[NumChan-1:0];
  assign toggleBits = regWrData[RegW-1:HalfW];

  // One flag per channel: a completion has priority over a clear.
  for (genvar i = 0; i < NumChan; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                         statusQ[i] <= 1'b0;
      else if (chanDone[i])              statusQ[i] <= 1'b1;
      else if (stb.statWr && clrBits[i]) statusQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           maskQ <= '0;
    else if (stb.statWr) maskQ <= maskQ ^ toggleBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           ctrlQ <= '0;
    else if (stb.ctrlWr) ctrlQ <= regWrData[NumChan-1:0];
  end

  assign pendVec = maskQ[NumChan-1:0] & statusQ;
  assign condNow = &(statusQ | ~ctrlQ);

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |pendVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             condQ <= 1'b1;
    else if (stb.condLoad) condQ <= condNow;
  end

  always_comb begin
    statusWide              = '0;
    statusWide[NumChan-1:0] = statusQ;
    ctrlWide                = '0;
    ctrlWide[NumChan-1:0]   = ctrlQ;
  end

  assign regRdData  = regSel ? ctrlWide : {maskQ, statusWide};
  assign irqPending = irqQ;
  assign waitCond   = condQ;

  // R2: a completion pulse leaves its flag set
  p_done_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|chanDone) |=> ((statusQ & $past(chanDone)) == $past(chanDone)));

  // R3: a cleared flag without a simultaneous completion reads zero
  p_clear_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.statWr |=> ((statusQ & $past(clrBits & ~chanDone)) == '0));

  // R4: enable bits toggle under a write and hold otherwise
  p_toggle_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.statWr |=> (maskQ == $past(maskQ ^ toggleBits)));
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.statWr |=> $stable(maskQ));

  // R5: the interrupt line follows enabled pending flags by one cycle
  p_irq_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqPending == $past(|(maskQ[NumChan-1:0] & statusQ))));

  // R6: the select word changes only on its own write
  p_select_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ctrlWr |=> $stable(ctrlQ));

  // R8: the wait condition only moves on a reload
  p_cond_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.condLoad |=> $stable(waitCond));

  // R9: completion beats a clear of the same flag
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.statWr && |(chanDone & clrBits)) |=>
      ((statusQ & $past(chanDone & clrBits)) == $past(chanDone & clrBits)));

endmodule

// File: rtl/dma_irq_cond_unit.sv
module dma_irq_cond_unit
  import dmairq_pkg::*;
#(
  parameter int NumChan = DefNumChan,
  parameter int RegW    = DefRegW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumChan-1:0] chanDone,
  input  logic               regWrEn,
  input  logic               regSel,
  input  logic [RegW-1:0]    regWrData,
  output logic [RegW-1:0]    regRdData,
  output logic               irqPending,
  output logic               waitCond
);

  dmairq_strobe_t stb;

  dmairq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regSel  (regSel),
    .stb     (stb)
  );

  dmairq_datapath #(
    .NumChan (NumChan),
    .RegW    (RegW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .chanDone   (chanDone),
    .regSel     (regSel),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .irqPending (irqPending),
    .waitCond   (waitCond)
  );

endmodule

// File: tb/sim_dma_irq_cond_unit.sv
`timescale 1ns/1ps
module sim_dma_irq_cond_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  chanDone = '0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqPending;
  logic        waitCond;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_irq_cond_unit u0 (
    .clk(clk), .rstN(rstN), .chanDone(chanDone), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .irqPending(irqPending), .waitCond(waitCond)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic        wrSel;
    logic [31:0] data;
    logic [9:0]  done;
    logic        rdSel;
    logic [31:0] expRd;
    logic        expIrq;
    logic        expCond;
  } vec_t;

  localparam int NVec = 14;
  localparam vec_t Vecs [NVec] = '{
    '{4'd2, 1'b0, 1'b0, 32'h0000_0000, 10'h005, 1'b0, 32'h0000_0005, 1'b0, 1'b1}, // R2 ch0,ch2 done
    '{4'd4, 1'b1, 1'b0, 32'h0001_0000, 10'h000, 1'b0, 32'h0001_0005, 1'b1, 1'b1}, // R4 R5 enable ch0
    '{4'd4, 1'b1, 1'b0, 32'h0001_0000, 10'h000, 1'b0, 32'h0000_0005, 1'b0, 1'b1}, // R4 toggle back
    '{4'd6, 1'b1, 1'b1, 32'h0000_0204, 10'h000, 1'b1, 32'h0000_0204, 1'b0, 1'b0}, // R6 R7 select ch2,ch9
    '{4'd8, 1'b0, 1'b0, 32'h0000_0000, 10'h200, 1'b0, 32'h0000_0205, 1'b0, 1'b0}, // R8 no reload
    '{4'd7, 1'b1, 1'b0, 32'h0000_0000, 10'h000, 1'b0, 32'h0000_0205, 1'b0, 1'b1}, // R7 reload
    '{4'd3, 1'b1, 1'b0, 32'h0000_0004, 10'h000, 1'b0, 32'h0000_0201, 1'b0, 1'b0}, // R3 clear ch2
    '{4'd5, 1'b1, 1'b0, 32'h0200_0000, 10'h000, 1'b0, 32'h0200_0201, 1'b1, 1'b0}, // R5 enable ch9
    '{4'd9, 1'b1, 1'b0, 32'h0000_0201, 10'h001, 1'b0, 32'h0200_0001, 1'b0, 1'b0}, // R9 set wins ch0
    '{4'd5, 1'b1, 1'b0, 32'hFC00_0000, 10'h000, 1'b0, 32'hFE00_0001, 1'b0, 1'b0}, // R5 high enables inert
    '{4'd7, 1'b1, 1'b1, 32'hFFFF_FC00, 10'h000, 1'b1, 32'h0000_0000, 1'b0, 1'b1}, // R7 none selected
    '{4'd6, 1'b1, 1'b1, 32'h0000_0001, 10'h000, 1'b0, 32'hFE00_0001, 1'b0, 1'b1}, // R6 flags untouched
    '{4'd5, 1'b1, 1'b0, 32'h0001_0000, 10'h000, 1'b0, 32'hFE01_0001, 1'b1, 1'b1}, // R5 enable ch0
    '{4'd2, 1'b0, 1'b0, 32'h0000_0000, 10'h3FF, 1'b0, 32'hFE01_03FF, 1'b1, 1'b1}  // R2 all channels
  };

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v);
    @(negedge clk);
    regWrEn = v.wr; regSel = v.wrSel; regWrData = v.data; chanDone = v.done;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; chanDone = '0; regSel = v.rdSel;
    @(negedge clk);
    check32($sformatf("R%0d rd", v.req), regRdData, v.expRd);
    check32($sformatf("R%0d irq", v.req), {31'b0, irqPending}, {31'b0, v.expIrq});
    check32($sformatf("R%0d cond", v.req), {31'b0, waitCond}, {31'b0, v.expCond});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regSel = 1'b0;
    check32("R1 status word", regRdData, 32'h0);
    check32("R1 irq", {31'b0, irqPending}, 32'h0);
    check32("R1 cond", {31'b0, waitCond}, 32'h1);
    regSel = 1'b1;
    check32("R1 select word", regRdData, 32'h0);

    for (int k = 0; k < NVec; k++) runVec(Vecs[k]);

    // R9 all flags: clear everything while every channel completes
    @(negedge clk);
    regWrEn = 1'b1; regSel = 1'b0; regWrData = 32'h0000_FFFF; chanDone = 10'h3FF;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; chanDone = '0;
    check32("R9 all set win", regRdData, 32'hFE01_03FF);

    // R3 plain clear of all flags drops the interrupt next cycle (R5)
    regWrEn = 1'b1; regWrData = 32'h0000_03FF;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    check32("R3 all cleared", regRdData, 32'hFE01_0000);
    @(negedge clk);
    check32("R5 irq dropped", {31'b0, irqPending}, 32'h0);
    check32("R7 cond after clear", {31'b0, waitCond}, 32'h0);

    // R1 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check32("R1 rerun status", regRdData, 32'h0);
    check32("R1 rerun irq", {31'b0, irqPending}, 32'h0);
    check32("R1 rerun cond", {31'b0, waitCond}, 32'h1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule